// File: doc/BRIEF.md
# CAN Transmit Mailbox Bank

The block keeps three transmit mailboxes for a CAN controller behind a 32-bit register port. Each mailbox holds an identifier word, a length word and two data words. Software fills the length and data words first, then writes the identifier word with its request bit set to queue the frame. The bank then chooses which queued mailbox goes next to the protocol engine. The engine takes a frame over a valid/ready handshake and reports the end of transmission with a one-cycle done pulse.

The selection rule is set by a mode bit. In one mode the frame with the lowest identifier goes first. In the other mode frames go in the order software queued them. Only one frame is with the engine at a time. When a frame completes, a per-mailbox completion flag is set in a shared status word. Software clears a flag by writing a one to it. The transmit interrupt is raised while any flag is set and the interrupt enable bit is on.

Top module: `can_txmb_bank`

## Requirements
- R1: After reset, no mailbox is pending, all flags and registers read zero, and `tx_valid_o` and `tx_irq_o` are low.
- R2: Register map, byte addresses:
  - control at 0x00: bit 0 = order mode.
  - status at 0x04.
  - interrupt enable at 0x08: bit 0.
  - Mailbox m starts at 0x10+16·m, with the identifier word at +0, the length word at +4, data word 0 at +8 and data word 1 at +C.
  - The length word stores and returns only bits 3:0 (the length code). Its upper bits read zero.
  - Reads are combinational.
- R3: Writing a mailbox identifier word with bit 0 = 1 queues that mailbox. Bit 0 then reads back 1 until the engine accepts the frame (`tx_valid_o && tx_ready_i` at an edge), and reads 0 after that edge.
- R4: With control bit 0 = 0, the pending mailbox with the lowest key goes first. The key is {id[31:21], id[2], id[2] ? id[20:3] : 0}. Bit 2 marks the extended format, so a standard frame beats an extended frame with the same base. When keys are equal, the lower mailbox index goes first.
- R5: With control bit 0 = 1, pending mailboxes go in the order their requests were written.
- R6: After an accept, `tx_valid_o` stays low until `tx_done_i`. A `tx_done_i` with no frame in flight has no effect.
- R7: While `tx_valid_o` is high, the frame outputs show the selected mailbox:
  - `tx_mbox_o` gives its index.
  - `tx_idw_o` gives its identifier word with bit 0 zero.
  - `tx_dlc_o` gives its length code.
  - The data outputs give its data words, except for a remote frame (identifier bit 1 = 1), whose data outputs are zero whatever its length code.
- R8: On `tx_done_i`, the flag of the in-flight mailbox m is set at status bit 8·m. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. If a set and a clear hit the same flag in the same cycle, the set wins.
- R9: `tx_irq_o` is high exactly when enable bit 0 is 1 and at least one completion flag is set.
- R10: Writes to any word of a mailbox whose request is pending are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tx_valid_o | output | 1 | A frame is offered to the engine |
| tx_ready_i | input | 1 | Engine accepts the offered frame |
| tx_mbox_o | output | 2 | Index of the offered mailbox |
| tx_idw_o | output | 32 | Identifier word of the offered frame |
| tx_dlc_o | output | 4 | Length code of the offered frame |
| tx_data0_o | output | 32 | Data word 0 (zero for remote frames) |
| tx_data1_o | output | 32 | Data word 1 (zero for remote frames) |
| tx_done_i | input | 1 | Engine finished the in-flight frame |
| tx_irq_o | output | 1 | Transmit interrupt |

## Verification
Read data is due in the same cycle as the address. A write becomes visible in readback right after the edge that captures it. `tx_valid_o` and the selected frame appear right after the edge that captures the queuing write. The request bit clears and `tx_valid_o` falls right after the accept edge. A completion flag, and with it the interrupt, rises right after the done edge. The bench changes inputs just after each rising edge and compares every output with a behavioural model at the falling edge, so each expected value is taken one edge after its cause.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
  localparam int BASE_W = 11;
  localparam int EXT_W  = 18;
  localparam int KEY_W  = BASE_W + 1 + EXT_W;

  typedef struct packed {
    logic [31:1] idw;
    logic [3:0]  dlc;
    logic [31:0] d0;
    logic [31:0] d1;
  } mb_frame_t;

  // Lower key wins: base id, then standard before extended, then extended bits.
  function automatic logic [KEY_W-1:0] prio_key(input logic [31:1] idw);
    return {idw[31:21], idw[2], (idw[2] ? idw[20:3] : {EXT_W{1'b0}})};
  endfunction
endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
  import can_txmb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  word_i,
  input  logic [31:0] wdata_i,
  input  logic        accept_i,
  output logic        pend_o,
  output logic        req_set_o,
  output mb_frame_t   frame_o
);
  logic      pend_q;
  mb_frame_t frm_q;
  logic      wr_ok;

  assign wr_ok     = we_i & ~pend_q;
  assign req_set_o = wr_ok & (word_i == 2'd0) & wdata_i[0];
  assign pend_o    = pend_q;
  assign frame_o   = frm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      frm_q  <= '0;
    end else begin
      if (accept_i) pend_q <= 1'b0;
      if (wr_ok) begin
        unique case (word_i)
          2'd0: begin
            frm_q.idw <= wdata_i[31:1];
            pend_q    <= wdata_i[0];
          end
          2'd1:    frm_q.dlc <= wdata_i[3:0];
          2'd2:    frm_q.d0  <= wdata_i;
          default: frm_q.d1  <= wdata_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_txmb_arb.sv
module can_txmb_arb
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB = 3,
  parameter int IDX_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_MB-1:0]             pend_i,
  input  logic [NUM_MB-1:0]             req_set_i,
  input  logic [NUM_MB-1:0][KEY_W-1:0]  key_i,
  input  logic                          order_mode_i,
  output logic                          any_o,
  output logic [IDX_W-1:0]              sel_o
);
  // older_q[i][j]: mailbox i was requested before mailbox j
  logic [NUM_MB-1:0] older_q [NUM_MB];
  logic [NUM_MB-1:0] oldest;
  logic [IDX_W-1:0]  sel_id, sel_ord;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_MB; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (req_set_i[i]) begin
          for (int j = 0; j < NUM_MB; j++) begin
            if (j != i) begin
              older_q[i][j] <= 1'b0;
              older_q[j][i] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_MB; i++) begin
      oldest[i] = pend_i[i];
      for (int j = 0; j < NUM_MB; j++)
        if (j != i && pend_i[j] && !older_q[i][j]) oldest[i] = 1'b0;
    end
  end

  always_comb begin
    sel_ord = '0;
    for (int i = NUM_MB - 1; i >= 0; i--)
      if (oldest[i]) sel_ord = IDX_W'(i);
  end

  always_comb begin
    logic             found;
    logic [KEY_W-1:0] best_k;
    found  = 1'b0;
    best_k = '1;
    sel_id = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pend_i[i] && (!found || key_i[i] < best_k)) begin
        found  = 1'b1;
        best_k = key_i[i];
        sel_id = IDX_W'(i);
      end
    end
  end

  assign any_o = |pend_i;
  assign sel_o = order_mode_i ? sel_ord : sel_id;
endmodule

// File: rtl/can_txmb_stat.sv
module can_txmb_stat #(
  parameter int NUM_MB = 3,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [IDX_W-1:0]  acc_idx_i,
  input  logic              done_i,
  input  logic [NUM_MB-1:0] clr_i,
  input  logic              ie_i,
  output logic              busy_o,
  output logic [NUM_MB-1:0] flags_o,
  output logic              irq_o
);
  logic              busy_q;
  logic [IDX_W-1:0]  cur_q;
  logic [NUM_MB-1:0] flag_q;
  logic [NUM_MB-1:0] set_v;

  always_comb begin
    for (int m = 0; m < NUM_MB; m++)
      set_v[m] = done_i & busy_q & (cur_q == IDX_W'(m));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_i) | set_v;
      if (done_i && busy_q) busy_q <= 1'b0;
      if (accept_i) begin
        busy_q <= 1'b1;
        cur_q  <= acc_idx_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign flags_o = flag_q;
  assign irq_o   = ie_i & (|flag_q);
endmodule

// File: rtl/can_txmb_bank.sv
module can_txmb_bank
  import can_txmb_pkg::*;
#(
  parameter int NUM_MB   = 3,
  parameter int ADDR_W   = 8,
  parameter int MB_BASE  = 16,
  parameter int CTRL_OFS = 0,
  parameter int STAT_OFS = 4,
  parameter int IE_OFS   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [1:0]  tx_mbox_o,
  output logic [31:0] tx_idw_o,
  output logic [3:0]  tx_dlc_o,
  output logic [31:0] tx_data0_o,
  output logic [31:0] tx_data1_o,
  input  logic        tx_done_i,
  output logic        tx_irq_o
);
  localparam int IDX_W    = 2;
  localparam int HI_W     = ADDR_W - 4;
  localparam int FLAG_GAP = 8;

  logic                         mode_q, ie_q;
  logic                         ctrl_hit, stat_hit, ie_hit;
  logic [NUM_MB-1:0]            mb_hit, mb_pend, req_set, acc_v, clr_v, flags;
  logic [NUM_MB-1:0][KEY_W-1:0] keys;
  mb_frame_t                    frames [NUM_MB];
  mb_frame_t                    sel_frame;
  logic                         any_pend, busy, accept;
  logic [IDX_W-1:0]             sel;
  logic [31:0]                  stat_word;

  assign ctrl_hit = reg_addr_i == ADDR_W'(CTRL_OFS);
  assign stat_hit = reg_addr_i == ADDR_W'(STAT_OFS);
  assign ie_hit   = reg_addr_i == ADDR_W'(IE_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (reg_we_i) begin
      if (ctrl_hit) mode_q <= reg_wdata_i[0];
      if (ie_hit)   ie_q   <= reg_wdata_i[0];
    end
  end

  assign accept = tx_valid_o & tx_ready_i;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    assign mb_hit[g] = reg_addr_i[ADDR_W-1:4] == HI_W'(MB_BASE / 16 + g);
    assign acc_v[g]  = accept & (sel == IDX_W'(g));
    assign clr_v[g]  = reg_we_i & stat_hit & reg_wdata_i[FLAG_GAP*g];
    assign keys[g]   = prio_key(frames[g].idw);

    can_txmb_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (reg_we_i & mb_hit[g]),
      .word_i    (reg_addr_i[3:2]),
      .wdata_i   (reg_wdata_i),
      .accept_i  (acc_v[g]),
      .pend_o    (mb_pend[g]),
      .req_set_o (req_set[g]),
      .frame_o   (frames[g])
    );
  end

  can_txmb_arb #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pend_i       (mb_pend),
    .req_set_i    (req_set),
    .key_i        (keys),
    .order_mode_i (mode_q),
    .any_o        (any_pend),
    .sel_o        (sel)
  );

  can_txmb_stat #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .acc_idx_i (sel),
    .done_i    (tx_done_i),
    .clr_i     (clr_v),
    .ie_i      (ie_q),
    .busy_o    (busy),
    .flags_o   (flags),
    .irq_o     (tx_irq_o)
  );

  always_comb begin
    sel_frame = frames[0];
    for (int m = 1; m < NUM_MB; m++)
      if (sel == IDX_W'(m)) sel_frame = frames[m];
  end

  assign tx_valid_o = any_pend & ~busy;
  assign tx_mbox_o  = sel;
  assign tx_idw_o   = {sel_frame.idw, 1'b0};
  assign tx_dlc_o   = sel_frame.dlc;
  assign tx_data0_o = sel_frame.idw[1] ? 32'h0 : sel_frame.d0;
  assign tx_data1_o = sel_frame.idw[1] ? 32'h0 : sel_frame.d1;

  always_comb begin
    stat_word = '0;
    for (int m = 0; m < NUM_MB; m++) stat_word[FLAG_GAP*m] = flags[m];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (ctrl_hit) reg_rdata_o = {31'h0, mode_q};
    if (stat_hit) reg_rdata_o = stat_word;
    if (ie_hit)   reg_rdata_o = {31'h0, ie_q};
    for (int m = 0; m < NUM_MB; m++) begin
      if (mb_hit[m]) begin
        unique case (reg_addr_i[3:2])
          2'd0:    reg_rdata_o = {frames[m].idw, mb_pend[m]};
          2'd1:    reg_rdata_o = {28'h0, frames[m].dlc};
          2'd2:    reg_rdata_o = frames[m].d0;
          default: reg_rdata_o = frames[m].d1;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_txmb_chk.sv
module can_txmb_chk #(
  parameter int NUM_MB = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [1:0]        tx_mbox_o,
  input logic [31:0]       tx_idw_o,
  input logic [31:0]       tx_data0_o,
  input logic [31:0]       tx_data1_o,
  input logic              tx_done_i,
  input logic              tx_irq_o,
  input logic [NUM_MB-1:0] mb_pend,
  input logic [NUM_MB-1:0] flags,
  input logic              busy
);
  p_accept_clears_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> !mb_pend[$past(tx_mbox_o)]);

  p_valid_is_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (int'(tx_mbox_o) < NUM_MB) && mb_pend[tx_mbox_o]);

  p_one_in_flight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> !tx_valid_o);

  p_remote_no_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_idw_o[1] |-> tx_data0_o == 32'h0 && tx_data1_o == 32'h0);

  p_done_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && busy |=> |flags);

  p_irq_has_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_irq_o) |-> $past(tx_done_i) || $past(reg_we_i));
endmodule

bind can_txmb_bank can_txmb_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_mbox_o  (tx_mbox_o),
  .tx_idw_o   (tx_idw_o),
  .tx_data0_o (tx_data0_o),
  .tx_data1_o (tx_data1_o),
  .tx_done_i  (tx_done_i),
  .tx_irq_o   (tx_irq_o),
  .mb_pend    (mb_pend),
  .flags      (flags),
  .busy       (busy)
);

// File: tb/can_txmb_bank_bench.sv
module can_txmb_bank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tx_valid_o, tx_ready_i = 1'b0;
  logic [1:0]  tx_mbox_o;
  logic [31:0] tx_idw_o, tx_data0_o, tx_data1_o;
  logic [3:0]  tx_dlc_o;
  logic        tx_done_i = 1'b0;
  logic        tx_irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  can_txmb_bank u_can_txmb_bank (.*);

  // behavioural reference model
  bit [31:0] m_idw [3];
  bit [3:0]  m_dlc [3];
  bit [31:0] m_d0 [3];
  bit [31:0] m_d1 [3];
  bit [2:0]  m_pend, m_flag, pend0;
  int        order_q [$];
  bit        m_busy, m_mode, m_ie, acc_m;
  int        m_cur, s_m, mb_m;

  function automatic bit [29:0] key_of(bit [31:0] w);
    return {w[31:21], w[2], w[2] ? w[20:3] : 18'h0};
  endfunction

  function automatic bit exp_valid();
    return (m_pend != 0) && !m_busy;
  endfunction

  function automatic int exp_sel();
    int best = -1;
    if (m_mode) return (order_q.size() > 0) ? order_q[0] : 0;
    for (int i = 0; i < 3; i++)
      if (m_pend[i] && (best < 0 || key_of(m_idw[i]) < key_of(m_idw[best]))) best = i;
    return (best < 0) ? 0 : best;
  endfunction

  function automatic bit [31:0] exp_rd(bit [7:0] a);
    int m;
    if (a == 8'h00) return {31'h0, m_mode};
    if (a == 8'h04) return {15'h0, m_flag[2], 7'h0, m_flag[1], 7'h0, m_flag[0]};
    if (a == 8'h08) return {31'h0, m_ie};
    if (a >= 8'h10 && a < 8'h40) begin
      m = (int'(a) - 16) / 16;
      case (a[3:2])
        2'd0: return {m_idw[m][31:1], m_pend[m]};
        2'd1: return {28'h0, m_dlc[m]};
        2'd2: return m_d0[m];
        default: return m_d1[m];
      endcase
    end
    return 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) begin
        m_idw[i] = 0; m_dlc[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
      end
      m_pend = 0; m_flag = 0; m_busy = 0; m_mode = 0; m_ie = 0; m_cur = 0;
      order_q.delete();
    end else begin
      acc_m = exp_valid() && tx_ready_i;
      s_m   = exp_sel();
      pend0 = m_pend;
      if (reg_we_i && reg_addr_i == 8'h04)
        for (int i = 0; i < 3; i++) if (reg_wdata_i[8*i]) m_flag[i] = 0;
      if (tx_done_i && m_busy) begin
        m_flag[m_cur] = 1;
        m_busy = 0;
      end
      if (acc_m) begin
        m_pend[s_m] = 0;
        for (int k = 0; k < order_q.size(); k++)
          if (order_q[k] == s_m) begin order_q.delete(k); break; end
        m_busy = 1;
        m_cur  = s_m;
      end
      if (reg_we_i) begin
        if (reg_addr_i == 8'h00) m_mode = reg_wdata_i[0];
        if (reg_addr_i == 8'h08) m_ie = reg_wdata_i[0];
        if (reg_addr_i >= 8'h10 && reg_addr_i < 8'h40) begin
          mb_m = (int'(reg_addr_i) - 16) / 16;
          if (!pend0[mb_m]) begin
            case (reg_addr_i[3:2])
              2'd0: begin
                m_idw[mb_m] = reg_wdata_i;
                if (reg_wdata_i[0]) begin
                  m_pend[mb_m] = 1;
                  order_q.push_back(mb_m);
                end
              end
              2'd1: m_dlc[mb_m] = reg_wdata_i[3:0];
              2'd2: m_d0[mb_m] = reg_wdata_i;
              default: m_d1[mb_m] = reg_wdata_i;
            endcase
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      chk(tx_valid_o == exp_valid(), "R6 valid", 32'(tx_valid_o), 32'(exp_valid()));
      if (exp_valid()) begin
        int s;
        s = exp_sel();
        chk(tx_mbox_o == 2'(s), m_mode ? "R5 order sel" : "R4 id sel", 32'(tx_mbox_o), 32'(s));
        chk(tx_idw_o == {m_idw[s][31:1], 1'b0}, "R7 idw", tx_idw_o, {m_idw[s][31:1], 1'b0});
        chk(tx_dlc_o == m_dlc[s], "R7 dlc", 32'(tx_dlc_o), 32'(m_dlc[s]));
        chk(tx_data0_o == (m_idw[s][1] ? 32'h0 : m_d0[s]), "R7 data0", tx_data0_o,
            m_idw[s][1] ? 32'h0 : m_d0[s]);
        chk(tx_data1_o == (m_idw[s][1] ? 32'h0 : m_d1[s]), "R7 data1", tx_data1_o,
            m_idw[s][1] ? 32'h0 : m_d1[s]);
      end
      chk(tx_irq_o == (m_ie && m_flag != 0), "R9 irq", 32'(tx_irq_o), 32'(m_ie && m_flag != 0));
    end
  end

  // stimulus tasks: called just after a rising edge
  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 0;
  endtask

  task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
    reg_addr_i = a; #1;
    chk(reg_rdata_o == exp, tag, reg_rdata_o, exp);
    chk(reg_rdata_o == exp_rd(a), {tag, " model"}, reg_rdata_o, exp_rd(a));
  endtask

  task automatic accept();
    tx_ready_i = 1;
    @(posedge clk_i); #1;
    tx_ready_i = 0;
  endtask

  task automatic done();
    tx_done_i = 1;
    @(posedge clk_i); #1;
    tx_done_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic send_one();
    accept(); idle(1); done();
  endtask

  function automatic bit [31:0] std_id(bit [10:0] id);
    return {id, 21'h0};
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1;
    idle(1);
    // R1 reset state
    chk(tx_valid_o == 0, "R1 valid", 32'(tx_valid_o), 0);
    chk(tx_irq_o == 0, "R1 irq", 32'(tx_irq_o), 0);
    rd(8'h00, 0, "R1 ctrl");
    rd(8'h04, 0, "R1 status");
    rd(8'h10, 0, "R1 mb0 id");
    rd(8'h34, 0, "R1 mb2 len");

    // R2 register map
    wr(8'h24, 32'hFFFF_FFFA);
    rd(8'h24, 32'h0000_000A, "R2 len field");
    wr(8'h28, 32'h1111_2222);
    rd(8'h28, 32'h1111_2222, "R2 data0");
    wr(8'h00, 1);
    rd(8'h00, 1, "R2 ctrl");
    wr(8'h00, 0);
    wr(8'h08, 1);
    rd(8'h08, 1, "R2 ie");

    // R4 identifier priority: std 0x100 beats ext base 0x100 beats std 0x300
    wr(8'h14, 4); wr(8'h18, 32'hA0A0_A0A0); wr(8'h1C, 32'h0B0B_0B0B);
    wr(8'h10, std_id(11'h300) | 1);
    wr(8'h2C, 32'h3333_4444);
    wr(8'h20, {11'h100, 18'h00005, 3'b101});
    wr(8'h34, 2); wr(8'h38, 32'h5555_6666); wr(8'h3C, 32'h7777_8888);
    wr(8'h30, std_id(11'h100) | 1);
    rd(8'h10, std_id(11'h300) | 1, "R3 request reads 1");
    // R10 writes to pending mailbox dropped
    wr(8'h18, 32'hDEAD_BEEF);
    wr(8'h10, std_id(11'h001) | 1);
    rd(8'h18, 32'hA0A0_A0A0, "R10 data kept");
    rd(8'h10, std_id(11'h300) | 1, "R10 id kept");
    chk(tx_mbox_o == 2, "R4 std before ext", 32'(tx_mbox_o), 2);
    accept();
    rd(8'h30, std_id(11'h100), "R3 request cleared");
    chk(tx_valid_o == 0, "R6 no offer in flight", 32'(tx_valid_o), 0);
    idle(2);
    done();
    rd(8'h04, 32'h0001_0000, "R8 flag mb2");
    chk(tx_irq_o == 1, "R9 irq on", 32'(tx_irq_o), 1);
    chk(tx_mbox_o == 1, "R4 ext before higher std", 32'(tx_mbox_o), 1);
    send_one();
    chk(tx_mbox_o == 0, "R4 last", 32'(tx_mbox_o), 0);
    send_one();
    rd(8'h04, 32'h0001_0101, "R8 all flags");

    // R8 write-one-to-clear
    wr(8'h04, 32'h0000_0100);
    rd(8'h04, 32'h0001_0001, "R8 w1c one");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h0001_0001, "R8 zero write");
    // R9 enable gating
    wr(8'h08, 0);
    chk(tx_irq_o == 0, "R9 masked", 32'(tx_irq_o), 0);
    wr(8'h08, 1);
    wr(8'h04, 32'h0001_0001);
    chk(tx_irq_o == 0, "R9 all clear", 32'(tx_irq_o), 0);
    // R6 stray done
    done();
    rd(8'h04, 0, "R6 stray done");

    // R4 tie goes to lower index
    wr(8'h20, std_id(11'h055) | 1);
    wr(8'h10, std_id(11'h055) | 1);
    chk(tx_mbox_o == 0, "R4 tie", 32'(tx_mbox_o), 0);
    accept(); idle(1);
    // R8 set beats clear in same cycle
    tx_done_i = 1; reg_we_i = 1; reg_addr_i = 8'h04; reg_wdata_i = 32'h1;
    @(posedge clk_i); #1;
    tx_done_i = 0; reg_we_i = 0;
    rd(8'h04, 32'h1, "R8 set wins");
    send_one();
    wr(8'h04, 32'h0001_0101);

    // R7 remote frame carries no data
    wr(8'h34, 8);
    wr(8'h30, std_id(11'h0AA) | 3);
    chk(tx_data0_o == 0 && tx_data1_o == 0, "R7 remote data", tx_data0_o, 0);
    chk(tx_dlc_o == 8, "R7 remote dlc", 32'(tx_dlc_o), 8);
    send_one();

    // R5 request order overrides identifiers
    wr(8'h00, 1);
    wr(8'h30, std_id(11'h7FF) | 1);
    wr(8'h10, std_id(11'h700) | 1);
    wr(8'h20, std_id(11'h001) | 1);
    chk(tx_mbox_o == 2, "R5 first", 32'(tx_mbox_o), 2);
    send_one();
    chk(tx_mbox_o == 0, "R5 second", 32'(tx_mbox_o), 0);
    send_one();
    chk(tx_mbox_o == 1, "R5 third", 32'(tx_mbox_o), 1);
    send_one();
    rd(8'h04, 32'h0001_0101, "R8 final flags");
    idle(2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule